// File: doc/BRIEF.md
# I2C Repeated-START Sequencer with Collision Detection

This block lets an I2C master issue a repeated START while it watches for a second master on the bus. On a request it first lets SDA float high while it keeps SCL low for one baud period. It then releases SCL and waits until SCL is seen high. Next it holds both lines released for a second baud period, and then it pulls SDA low for a third. At the end of that third period it pulls SCL low and emits a one-cycle completion pulse. A single 7-bit reload value sets all three periods, and an internal down-counter produces them.

Two situations count as lost arbitration, and each aborts the sequence. In the first, SDA is low at the moment SCL is first seen high, which means another master is sending a 0. In the second, SCL drops during the second period while SDA is still high, which means another master is sending a 1. On an abort the block releases both lines, returns to idle and sets a sticky collision flag that software clears. SDA falling during the second period is not a collision: the block takes it as the START edge and moves straight to driving SDA low. The line inputs pass through a two-flop synchronizer before the sequencer uses them. The two outputs are pull-low enables for open-drain pads.

Top module: `i2c_rstart_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes idle: `scl_pull`, `sda_pull`, `done` and `collision` all read 0 after that edge.
- R2: A `start_req` accepted in idle sets `sda_pull`=0 and `scl_pull`=1 from the next edge for exactly N cycles, where N is `reload_val`. After those N cycles `scl_pull` drops to 0.
- R3: When synchronized SCL is high and synchronized SDA is high, both pulls stay 0 for N cycles. Then `sda_pull`=1 for N cycles with `scl_pull`=0. After that both pulls go to 1, and `done` is 1 for exactly one cycle.
- R4: If synchronized SDA is 0 while the block waits for SCL and synchronized SCL is 1, this is a collision.
- R5: During the second period, synchronized SCL at 0 while synchronized SDA is still 1 is a collision.
- R6: During the second period, synchronized SDA at 0 is not a collision. From the next edge the block pulls SDA low and starts the third period of N cycles.
- R7: On a collision, from the next edge `collision`=1, both pulls are 0, the block is idle and no `done` occurs.
- R8: `collision` stays 1 until a cycle with `clr_flag`=1 clears it at the next edge. If a new collision arrives in the same cycle as `clr_flag`, the set takes priority.
- R9: The level of SCL during the third period has no effect. At its end SCL is pulled low and `done` is pulsed.
- R10: A `reload_val` of 0 gives periods of one cycle.
- R11: `start_req` has no effect while a sequence is in progress.
- R12: `scl_in` and `sda_in` reach the sequencer two clock edges after they are sampled.
- R13: After `done`, the block stays idle with both pulls at 1 until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request for a repeated START; accepted only in idle |
| reload_val | input | 7 | Baud period in cycles (0 means 1) |
| clr_flag | input | 1 | Clears the collision flag |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_pull | output | 1 | 1 = pull SCL low |
| sda_pull | output | 1 | 1 = pull SDA low |
| done | output | 1 | One-cycle pulse when the repeated START is complete |
| collision | output | 1 | Sticky flag for lost arbitration |

## Verification
The bench models a wired-AND bus so that another master can hold either line low at chosen points. A reference model runs cycle by cycle in parallel with the design. The bench times a low SDA at the SCL sample point, which a design that skipped the check would answer with a `done`. It also times an SCL drop in the second period, which a design with the test inverted would miss. An early SDA fall in the second period must not be flagged, and a design that treated it as a collision would abort a good START. The remaining stimulus covers an SCL drop in the third period, which must be ignored, a reload of zero, which must not stall, requests sent while busy, which must not restart the sequence, and a clear arriving with a new collision, which must leave the flag set.

// File: rtl/i2c_rs_pkg.sv
// Shared types for the repeated-START sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_rs_pkg;
    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_SCL_LOW   = 3'd1,
        PH_WAIT_SCL  = 3'd2,
        PH_HOLD_HIGH = 3'd3,
        PH_SDA_LOW   = 3'd4
    } rs_phase_t;
endpackage

// File: rtl/rs_sync.sv
// Multi-flop synchronizer for one bus line.
// Assumes: the line idles high, so the stages reset to INIT.
module rs_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int WW = $clog2(STAGES + 1);

    logic [STAGES-1:0] pipe;
    logic [WW-1:0]     warm;

    // Shift the line level through the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {STAGES{INIT}};
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    // Count the edges since reset, up to the latency (used by the check only).
    always_ff @(posedge clk) begin
        if (!rst_n)                     warm <= '0;
        else if (warm != WW'(STAGES))   warm <= warm + 1'b1;
    end

    assign q = pipe[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            assert_sync_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
                (warm == WW'(STAGES)) |-> (q == $past(d, 2)));
        end
    endgenerate
endmodule

// File: rtl/rs_brg.sv
// Down-counting baud generator. A load starts a period of max(reload,1) cycles,
// and expire is high in the last cycle of that period.
// Assumes: load is a single-cycle strobe from the sequencer.
module rs_brg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] reload,
    output logic         expire
);
    logic [W-1:0] cnt;
    logic [W-1:0] eff;

    // A zero reload becomes one, so every period ends.
    always_comb eff = (reload == '0) ? W'(1) : reload;

    // Load or count down, and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= eff;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == W'(1));

    assert_load_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt != '0));
    assert_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt > W'(1)) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rs_seq.sv
// Sequencer for the repeated START. It steps through release, wait, hold and
// drive, and detects both arbitration-loss cases.
// Assumes: scl_s/sda_s are already synchronized; expire comes from rs_brg.
module rs_seq
    import i2c_rs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic clr_flag,
    input  logic scl_s,
    input  logic sda_s,
    input  logic expire,
    output logic brg_load,
    output logic scl_pull,
    output logic sda_pull,
    output logic done,
    output logic collision
);
    rs_phase_t phase, phase_n;
    logic      own_q, own_n;
    logic      coll, fin;

    // Next-phase logic with both collision checks.
    always_comb begin
        phase_n  = phase;
        brg_load = 1'b0;
        coll     = 1'b0;
        fin      = 1'b0;
        unique case (phase)
            PH_IDLE: if (start_req) begin
                phase_n  = PH_SCL_LOW;
                brg_load = 1'b1;
            end
            PH_SCL_LOW: if (expire) phase_n = PH_WAIT_SCL;
            PH_WAIT_SCL: if (scl_s) begin
                if (!sda_s) coll = 1'b1;
                else begin
                    phase_n  = PH_HOLD_HIGH;
                    brg_load = 1'b1;
                end
            end
            PH_HOLD_HIGH: begin
                if (!sda_s || expire) begin
                    phase_n  = PH_SDA_LOW;
                    brg_load = 1'b1;
                end else if (!scl_s) begin
                    coll = 1'b1;
                end
            end
            PH_SDA_LOW: if (expire) begin
                phase_n = PH_IDLE;
                fin     = 1'b1;
            end
            default: phase_n = PH_IDLE;
        endcase
        if (coll) phase_n = PH_IDLE;
    end

    // Bus ownership is taken on completion and dropped on a collision.
    always_comb begin
        own_n = own_q;
        if (fin)  own_n = 1'b1;
        if (coll) own_n = 1'b0;
    end

    // Phase and ownership registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            own_q <= 1'b0;
        end else begin
            phase <= phase_n;
            own_q <= own_n;
        end
    end

    // One-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= fin;
    end

    // Sticky collision flag: a new collision wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        collision <= 1'b0;
        else if (coll)     collision <= 1'b1;
        else if (clr_flag) collision <= 1'b0;
    end

    // Line pulls decoded from phase and ownership.
    always_comb begin
        scl_pull = (phase == PH_SCL_LOW) || (phase == PH_IDLE && own_q);
        sda_pull = (phase == PH_SDA_LOW) || (phase == PH_IDLE && own_q);
    end

    assert_abort_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        coll |=> (phase == PH_IDLE && !scl_pull && !sda_pull && collision && !done));
    assert_case_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT_SCL && scl_s && !sda_s) |=> collision);
    assert_case_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD_HIGH && !scl_s && sda_s && !expire) |=> collision);
    assert_early_sda_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD_HIGH && !sda_s) |=> (sda_pull && !scl_pull && phase == PH_SDA_LOW));
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (collision && !clr_flag) |=> collision);
    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (scl_pull && sda_pull));
    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_WAIT_SCL || phase == PH_HOLD_HIGH) && start_req && !coll)
            |=> (phase != PH_SCL_LOW));
endmodule

// File: rtl/i2c_rstart_gen.sv
// Top level of the repeated-START generator: synchronizers, baud counter and sequencer.
// Assumes: scl_in/sda_in are the pad levels; the pulls drive open-drain pads.
module i2c_rstart_gen #(
    parameter int RELOAD_W    = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_req,
    input  logic [RELOAD_W-1:0] reload_val,
    input  logic                clr_flag,
    input  logic                scl_in,
    input  logic                sda_in,
    output logic                scl_pull,
    output logic                sda_pull,
    output logic                done,
    output logic                collision
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] line_raw, line_s;
    logic              brg_load, expire;

    assign line_raw = {sda_in, scl_in};

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_sync
            rs_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .d    (line_raw[i]),
                .q    (line_s[i])
            );
        end
    endgenerate

    rs_brg #(.W(RELOAD_W)) u_brg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (brg_load),
        .reload(reload_val),
        .expire(expire)
    );

    rs_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_req(start_req),
        .clr_flag (clr_flag),
        .scl_s    (line_s[0]),
        .sda_s    (line_s[1]),
        .expire   (expire),
        .brg_load (brg_load),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull),
        .done     (done),
        .collision(collision)
    );
endmodule

// File: tb/i2c_rstart_gen_test.sv
module i2c_rstart_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0;
    logic [6:0] reload_val = 7'd3;
    logic       clr_flag = 1'b0;
    logic       ext_scl = 1'b1;
    logic       ext_sda = 1'b1;
    logic       scl_pull, sda_pull, done, collision;
    wire        scl_in = ext_scl & ~scl_pull;
    wire        sda_in = ext_sda & ~sda_pull;

    int total = 0;
    int fails = 0;
    int dones = 0;
    int coll_cycles = 0;
    string cur_req = "R1";

    // reference model state
    int m_ph = 0;
    int m_rem = 0;
    bit m_own = 0, m_flag = 0, m_done = 0;
    bit m_c1 = 1, m_c2 = 1, m_d1 = 1, m_d2 = 1;

    always #5 clk = ~clk;

    i2c_rstart_gen uut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .reload_val(reload_val),
        .clr_flag(clr_flag), .scl_in(scl_in), .sda_in(sda_in),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .done(done), .collision(collision)
    );

    function automatic bit m_scl_pull();
        return (m_ph == 1) || (m_ph == 0 && m_own);
    endfunction
    function automatic bit m_sda_pull();
        return (m_ph == 4) || (m_ph == 0 && m_own);
    endfunction

    task automatic model_edge();
        bit lc, ld, coll, fin;
        int eff;
        lc   = ext_scl & ~m_scl_pull();
        ld   = ext_sda & ~m_sda_pull();
        eff  = (reload_val == 0) ? 1 : int'(reload_val);
        coll = 0;
        fin  = 0;
        if (!rst_n) begin
            m_ph = 0; m_rem = 0; m_own = 0; m_flag = 0; m_done = 0;
            m_c1 = 1; m_c2 = 1; m_d1 = 1; m_d2 = 1;
            return;
        end
        case (m_ph)
            0: if (start_req) begin m_ph = 1; m_rem = eff; end
            1: if (m_rem == 1) m_ph = 2; else m_rem--;
            2: if (m_c2) begin
                   if (!m_d2) coll = 1;
                   else begin m_ph = 3; m_rem = eff; end
               end
            3: if (!m_d2) begin m_ph = 4; m_rem = eff; end
               else if (m_rem == 1) begin m_ph = 4; m_rem = eff; end
               else if (!m_c2) coll = 1;
               else m_rem--;
            4: if (m_rem == 1) begin m_ph = 0; fin = 1; m_own = 1; end else m_rem--;
            default: m_ph = 0;
        endcase
        if (coll) begin m_ph = 0; m_own = 0; end
        if (coll) m_flag = 1; else if (clr_flag) m_flag = 0;
        m_done = fin;
        m_c2 = m_c1; m_c1 = lc;
        m_d2 = m_d1; m_d1 = ld;
    endtask

    task automatic check(input logic act, input logic exp, input string req, input string what);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(scl_pull, m_scl_pull(), cur_req, "scl_pull vs model (R2 R3)");
        check(sda_pull, m_sda_pull(), cur_req, "sda_pull vs model (R3 R12)");
        check(done, m_done, cur_req, "done vs model");
        check(collision, m_flag, cur_req, "collision vs model");
        if (done === 1'b1) dones++;
        if (collision === 1'b1) coll_cycles++;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic until_phase(input int p, input int limit);
        for (int i = 0; i < limit && m_ph != p; i++) step();
    endtask

    task automatic pulse_start();
        start_req = 1'b1;
        step();
        start_req = 1'b0;
    endtask

    task automatic clear_flag();
        clr_flag = 1'b1;
        step();
        clr_flag = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        // R1 reset
        cur_req = "R1";
        steps(3);
        rst_n = 1'b1;
        check(scl_pull, 1'b0, "R1", "scl_pull after reset");
        check(sda_pull, 1'b0, "R1", "sda_pull after reset");
        check(done, 1'b0, "R1", "done after reset");
        check(collision, 1'b0, "R1", "collision after reset");
        steps(2);

        // R2 R3 R13 normal sequence
        cur_req = "R3";
        reload_val = 7'd3;
        dones = 0;
        pulse_start();
        check(scl_pull, 1'b1, "R2", "scl held low in first period");
        check(sda_pull, 1'b0, "R2", "sda released in first period");
        until_phase(0, 60);
        check(done, 1'b1, "R3", "done at completion");
        cur_req = "R13";
        steps(6);
        check(logic'(dones == 1), 1'b1, "R3", "single done pulse");
        check(scl_pull, 1'b1, "R13", "scl held after done");
        check(sda_pull, 1'b1, "R13", "sda held after done");

        // R11 requests while busy
        cur_req = "R11";
        reload_val = 7'd4;
        dones = 0;
        pulse_start();
        steps(2);
        start_req = 1'b1;
        steps(6);
        start_req = 1'b0;
        until_phase(0, 60);
        steps(3);
        check(logic'(dones == 1), 1'b1, "R11", "one completion despite busy requests");

        // R10 zero reload
        cur_req = "R10";
        reload_val = 7'd0;
        dones = 0;
        pulse_start();
        steps(20);
        check(logic'(dones == 1), 1'b1, "R10", "zero reload completes");

        // R12 short SCL low during the wait phase only delays
        cur_req = "R12";
        reload_val = 7'd3;
        dones = 0;
        pulse_start();
        until_phase(2, 30);
        ext_scl = 1'b0;
        step();
        ext_scl = 1'b1;
        until_phase(0, 60);
        steps(2);
        check(logic'(dones == 1), 1'b1, "R12", "completion after delayed SCL");

        // R4 SDA low at SCL sample
        cur_req = "R4";
        reload_val = 7'd5;
        dones = 0;
        ext_sda = 1'b0;
        pulse_start();
        until_phase(0, 60);
        steps(1);
        ext_sda = 1'b1;
        check(collision, 1'b1, "R4", "collision flag case one");
        check(scl_pull, 1'b0, "R7", "scl released after abort");
        check(sda_pull, 1'b0, "R7", "sda released after abort");
        check(logic'(dones == 0), 1'b1, "R7", "no done on abort");
        cur_req = "R8";
        steps(4);
        check(collision, 1'b1, "R8", "flag stays set");
        clear_flag();
        check(collision, 1'b0, "R8", "flag cleared");

        // R5 SCL low in second period
        cur_req = "R5";
        reload_val = 7'd8;
        dones = 0;
        pulse_start();
        until_phase(3, 40);
        steps(2);
        ext_scl = 1'b0;
        until_phase(0, 40);
        steps(1);
        ext_scl = 1'b1;
        check(collision, 1'b1, "R5", "collision flag case two");
        check(logic'(dones == 0), 1'b1, "R5", "no done case two");
        clear_flag();
        steps(4);

        // R6 early SDA fall in second period
        cur_req = "R6";
        reload_val = 7'd8;
        dones = 0;
        pulse_start();
        until_phase(3, 40);
        steps(2);
        ext_sda = 1'b0;
        until_phase(4, 10);
        check(sda_pull, 1'b1, "R6", "sda driven after early fall");
        ext_sda = 1'b1;
        until_phase(0, 40);
        steps(1);
        check(collision, 1'b0, "R6", "no collision on early SDA fall");
        check(logic'(dones == 1), 1'b1, "R6", "completes after early SDA fall");

        // R9 SCL low in third period is ignored
        cur_req = "R9";
        reload_val = 7'd6;
        dones = 0;
        pulse_start();
        until_phase(4, 40);
        ext_scl = 1'b0;
        until_phase(0, 40);
        steps(1);
        ext_scl = 1'b1;
        check(collision, 1'b0, "R9", "no collision with SCL low in third period");
        check(logic'(dones == 1), 1'b1, "R9", "done despite SCL low");
        check(scl_pull, 1'b1, "R9", "scl pulled low at end");

        // R8 set wins over a simultaneous clear
        cur_req = "R8";
        reload_val = 7'd5;
        coll_cycles = 0;
        ext_sda = 1'b0;
        clr_flag = 1'b1;
        pulse_start();
        until_phase(0, 60);
        steps(3);
        clr_flag = 1'b0;
        ext_sda = 1'b1;
        check(logic'(coll_cycles == 1), 1'b1, "R8", "set wins for one cycle under held clear");
        check(collision, 1'b0, "R8", "flag cleared afterwards");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule